// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar

This block holds the time of day and the calendar date as packed BCD bytes and moves them forward by one second on every cycle where the 1 Hz clock-enable input is high. That enable is expected to come from a divided 32.768 kHz timebase elsewhere in the chip. The calendar covers the years 2000 to 2099. A February has 29 days whenever the two-digit year is a multiple of four. A separate day-of-week counter turns over at midnight and is not derived from the date.

Software uses a byte-wide port to read and set the fields. The port has a 3-bit address, a write strobe, write data and combinational read data. A control byte carries a stop bit that is active when set, and it comes out of reset set, so time stays frozen until software clears it. Every field is a register clocked on the same edge. A read therefore never sees a set of fields that is only partly updated.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read as follows: control 0x80 (stopped), seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00. The address map is 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year.
- R2: While control bit 7 is 1, tick pulses change no time or date field. Writing 0 to that bit lets the ticks advance time.
- R3: Seconds count in BCD from 0x00 to 0x59. A tick at 0x59 wraps seconds to 0x00 and adds one minute. Minutes behave in the same way and carry into hours.
- R4: Hours count from 0x00 to 0x23. A tick at 23:59:59 gives 00:00:00, and on that same edge both the date and the weekday advance.
- R5: The weekday counts 1 to 7 and wraps to 1. It advances only at midnight and does not depend on the date.
- R6: Months 01, 03, 05, 07, 08, 10 and 12 end after date 0x31. Months 04, 06, 09 and 11 end after 0x30. A rollover sets the date to 0x01 and increments the month.
- R7: February ends after 0x29 if the binary value of the BCD year is divisible by 4. Otherwise it ends after 0x28.
- R8: A rollover from month 0x12 sets the month to 0x01 and increments the year. The year wraps from 0x99 to 0x00.
- R9: A write loads the addressed byte ANDed with the field mask. The masks are: control 0x80, seconds and minutes 0x7F, hours and date 0x3F, weekday 0x07, month 0x1F, year 0xFF. A write to a field wins over an increment of that field on the same edge. Carries out of the other fields still apply.
- R10: Fields change only on edges where the tick is high. All fields that change because of one tick show their new values together on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle clock enable, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |

## Verification
Time is preset by writes to just before each boundary: a seconds wrap, a minute-to-hour carry, midnight and each month end, followed by a single tick. This separates the carry chain from the per-field wrap values. All twelve month ends are tried in a non-leap year, and the last day of February is tried across leap and non-leap years, including 00 and 96. These cases tell the month-length table apart from the year-parity leap rule. Ticks sent while stopped, writes landing on the same edge as a tick, and writes of all-ones bytes show that the stop bit, the write priority and the field masks work apart from each other.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int ADDR_W  = 3;
  localparam int FIELD_W = 8;
  localparam int N_FIELD = 7;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_SEC   = 3'd1,
    RA_MIN   = 3'd2,
    RA_HOUR  = 3'd3,
    RA_WDAY  = 3'd4,
    RA_DATE  = 3'd5,
    RA_MONTH = 3'd6,
    RA_YEAR  = 3'd7
  } rtc_addr_e;

  // Add one to a two-digit packed BCD value (no wrap handling).
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // A BCD year is a multiple of four when: tens even and units 0/4/8,
  // or tens odd and units 2/6.
  function automatic logic bcd_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  // Last valid date (BCD) for a BCD month.
  function automatic logic [7:0] last_date(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int          W      = 8,
  parameter logic [W-1:0] MASK  = '1,
  parameter logic [W-1:0] FIRST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] last,
  output logic [W-1:0] value,
  output logic         wrap
);
  import rtc_pkg::*;

  logic at_end;
  assign at_end = (value >= last);
  assign wrap   = inc && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value <= FIRST;
    else if (wr)      value <= wdata & MASK;
    else if (inc)     value <= at_end ? FIRST : (bcd_next(value) & MASK);
  end

  AST_FIELD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> value == ($past(wdata) & MASK)); // R9
  AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr && value == last) |=> value == FIRST); // R3
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr) |=> $stable(value)); // R10

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_1hz,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata
);

  localparam logic [FIELD_W-1:0] FMASK  [1:N_FIELD] = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
  localparam logic [FIELD_W-1:0] FFIRST [1:N_FIELD] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

  logic               osc_off;      // stop bit, 1 = frozen
  logic               sec_step;
  logic [FIELD_W-1:0] fld   [1:N_FIELD];
  logic [FIELD_W-1:0] lim   [1:N_FIELD];
  logic               inc   [1:N_FIELD];
  logic               wrap  [1:N_FIELD];
  logic               wsel  [1:N_FIELD];
  logic               midnight;
  logic               feb_leap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        osc_off <= 1'b1;
    else if (wr_en && addr == RA_CTRL) osc_off <= wdata[7];
  end

  assign sec_step = tick_1hz && !osc_off;
  assign midnight = wrap[RA_HOUR];
  assign feb_leap = bcd_leap(fld[RA_YEAR]);

  always_comb begin
    lim[RA_SEC]   = 8'h59;
    lim[RA_MIN]   = 8'h59;
    lim[RA_HOUR]  = 8'h23;
    lim[RA_WDAY]  = 8'h07;
    lim[RA_DATE]  = last_date(fld[RA_MONTH], feb_leap);
    lim[RA_MONTH] = 8'h12;
    lim[RA_YEAR]  = 8'h99;
    inc[RA_SEC]   = sec_step;
    inc[RA_MIN]   = wrap[RA_SEC];
    inc[RA_HOUR]  = wrap[RA_MIN];
    inc[RA_WDAY]  = midnight;
    inc[RA_DATE]  = midnight;
    inc[RA_MONTH] = wrap[RA_DATE];
    inc[RA_YEAR]  = wrap[RA_MONTH];
  end

  for (genvar i = 1; i <= N_FIELD; i++) begin : g_field
    assign wsel[i] = wr_en && (addr == ADDR_W'(i));
    rtc_bcd_field #(.W(FIELD_W), .MASK(FMASK[i]), .FIRST(FFIRST[i])) u_field (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc[i]),
      .wr    (wsel[i]),
      .wdata (wdata),
      .last  (lim[i]),
      .value (fld[i]),
      .wrap  (wrap[i])
    );
  end

  always_comb begin
    case (addr)
      RA_CTRL:  rdata = {osc_off, 7'd0};
      RA_SEC:   rdata = fld[RA_SEC];
      RA_MIN:   rdata = fld[RA_MIN];
      RA_HOUR:  rdata = fld[RA_HOUR];
      RA_WDAY:  rdata = fld[RA_WDAY];
      RA_DATE:  rdata = fld[RA_DATE];
      RA_MONTH: rdata = fld[RA_MONTH];
      default:  rdata = fld[RA_YEAR];
    endcase
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_off && !wr_en) |=> $stable({fld[RA_SEC], fld[RA_MIN], fld[RA_HOUR], fld[RA_DATE]})); // R2
  AST_MIN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && !wr_en && fld[RA_SEC] == 8'h59 && fld[RA_MIN] == 8'h19) |=> fld[RA_MIN] == 8'h20); // R3
  AST_MIDNIGHT_WDAY: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && !wr_en && fld[RA_SEC] == 8'h59 && fld[RA_MIN] == 8'h59 && fld[RA_HOUR] == 8'h23
     && fld[RA_WDAY] == 8'h07) |=> (fld[RA_WDAY] == 8'h01 && fld[RA_HOUR] == 8'h00)); // R5
  AST_LEAP_FEB: assert property (@(posedge clk) disable iff (!rst_n)
    (midnight && !wr_en && fld[RA_MONTH] == 8'h02 && fld[RA_DATE] == 8'h28 && feb_leap)
      |=> fld[RA_DATE] == 8'h29); // R7
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (midnight && !wr_en && fld[RA_MONTH] == 8'h12 && fld[RA_DATE] == 8'h31 && fld[RA_YEAR] == 8'h99)
      |=> (fld[RA_YEAR] == 8'h00 && fld[RA_MONTH] == 8'h01 && fld[RA_DATE] == 8'h01)); // R8

endmodule

// File: tb/bcd_rtc_test.sv
module bcd_rtc_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  bcd_rtc uut (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
               .addr(addr), .wdata(wdata), .rdata(rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int exp_days(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m < 8)  return (m % 2 == 1) ? 31 : 30;
    return (m % 2 == 1) ? 30 : 31;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                         input logic [7:0] wd, input logic [7:0] dt, input logic [7:0] mo,
                         input logic [7:0] yr);
    wr(3'd3, h); wr(3'd2, m); wr(3'd1, s); wr(3'd4, wd);
    wr(3'd5, dt); wr(3'd6, mo); wr(3'd7, yr);
  endtask

  task automatic test_reset();
    logic [7:0] v;
    logic [7:0] expv [8] = '{8'h80, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R1", $sformatf("reset addr %0d", a), v, expv[a]);
    end
  endtask

  task automatic test_halt();
    logic [7:0] v;
    wr(3'd1, 8'h10);
    tick(); tick(); tick();
    rd(3'd1, v); chk("R2", "seconds while stopped", v, 8'h10);
    wr(3'd0, 8'h7F);
    rd(3'd0, v); chk("R9", "control low bits masked", v, 8'h00);
    tick();
    rd(3'd1, v); chk("R2", "seconds after start", v, 8'h11);
    repeat (4) @(negedge clk);
    rd(3'd1, v); chk("R10", "no change without tick", v, 8'h11);
    wr(3'd0, 8'hFF);
    rd(3'd0, v); chk("R2", "control reads stopped", v, 8'h80);
    tick();
    rd(3'd1, v); chk("R2", "stopped again", v, 8'h11);
    wr(3'd0, 8'h00);
  endtask

  task automatic test_carry();
    logic [7:0] v;
    set_all(8'h05, 8'h19, 8'h59, 8'h02, 8'h10, 8'h03, 8'h23);
    tick();
    rd(3'd1, v); chk("R3", "seconds wrap", v, 8'h00);
    rd(3'd2, v); chk("R3", "minute carry", v, 8'h20);
    rd(3'd3, v); chk("R3", "hour untouched", v, 8'h05);
    wr(3'd2, 8'h59); wr(3'd1, 8'h59);
    tick();
    rd(3'd2, v); chk("R3", "minutes wrap", v, 8'h00);
    rd(3'd3, v); chk("R3", "hour carry", v, 8'h06);
    rd(3'd4, v); chk("R5", "weekday only at midnight", v, 8'h02);
    wr(3'd1, 8'h09);
    tick();
    rd(3'd1, v); chk("R3", "units to tens", v, 8'h10);
  endtask

  task automatic test_midnight();
    logic [7:0] v;
    set_all(8'h23, 8'h59, 8'h59, 8'h07, 8'h15, 8'h06, 8'h41);
    tick();
    rd(3'd3, v); chk("R4", "hour wrap", v, 8'h00);
    rd(3'd5, v); chk("R4", "date advance", v, 8'h16);
    rd(3'd4, v); chk("R5", "weekday 7 to 1", v, 8'h01);
    set_all(8'h23, 8'h59, 8'h59, 8'h03, 8'h31, 8'h01, 8'h41);
    tick();
    rd(3'd4, v); chk("R5", "weekday independent of date", v, 8'h04);
    rd(3'd5, v); chk("R6", "date wrap Jan", v, 8'h01);
  endtask

  task automatic test_months();
    logic [7:0] v;
    for (int m = 1; m <= 12; m++) begin
      int d = exp_days(m, 23);
      set_all(8'h23, 8'h59, 8'h59, 8'h01, to_bcd(d - 1), to_bcd(m), 8'h23);
      tick();
      rd(3'd5, v); chk("R6", $sformatf("month %0d not ended early", m), v, to_bcd(d));
      wr(3'd3, 8'h23); wr(3'd2, 8'h59); wr(3'd1, 8'h59);
      tick();
      rd(3'd5, v); chk("R6", $sformatf("month %0d date rollover", m), v, 8'h01);
      rd(3'd6, v); chk("R6", $sformatf("month %0d next month", m), v, to_bcd(m % 12 + 1));
    end
  endtask

  task automatic test_feb();
    logic [7:0] v;
    int years [6] = '{0, 23, 24, 96, 98, 58};
    for (int i = 0; i < 6; i++) begin
      int y = years[i];
      bit lp = (y % 4 == 0);
      set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, to_bcd(y));
      tick();
      rd(3'd5, v); chk("R7", $sformatf("Feb 28 year %0d date", y), v, lp ? 8'h29 : 8'h01);
      rd(3'd6, v); chk("R7", $sformatf("Feb 28 year %0d month", y), v, lp ? 8'h02 : 8'h03);
    end
  endtask

  task automatic test_year();
    logic [7:0] v;
    set_all(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
    tick();
    rd(3'd7, v); chk("R8", "year 99 to 00", v, 8'h00);
    rd(3'd6, v); chk("R8", "month 12 to 01", v, 8'h01);
    rd(3'd5, v); chk("R10", "coherent date", v, 8'h01);
    rd(3'd1, v); chk("R10", "coherent seconds", v, 8'h00);
    rd(3'd4, v); chk("R10", "coherent weekday", v, 8'h06);
    set_all(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h49);
    tick();
    rd(3'd7, v); chk("R8", "year BCD carry", v, 8'h50);
  endtask

  task automatic test_write();
    logic [7:0] v;
    logic [7:0] mask [1:7] = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
    for (int a = 1; a <= 7; a++) begin
      wr(3'(a), 8'hFF);
      rd(3'(a), v); chk("R9", $sformatf("mask addr %0d", a), v, mask[a]);
    end
    wr(3'd2, 8'h10);
    wr(3'd1, 8'h30);
    @(negedge clk); tick_1hz = 1'b1; wr_en = 1'b1; addr = 3'd1; wdata = 8'h45;
    @(negedge clk); tick_1hz = 1'b0; wr_en = 1'b0;
    rd(3'd1, v); chk("R9", "write beats tick", v, 8'h45);
    wr(3'd1, 8'h59);
    @(negedge clk); tick_1hz = 1'b1; wr_en = 1'b1; addr = 3'd2; wdata = 8'h33;
    @(negedge clk); tick_1hz = 1'b0; wr_en = 1'b0;
    rd(3'd2, v); chk("R9", "minute write beats carry", v, 8'h33);
    rd(3'd1, v); chk("R9", "seconds still wrap", v, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_halt();
    test_carry();
    test_midnight();
    test_months();
    test_feb();
    test_year();
    test_write();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule